// File: doc/BRIEF.md
# Host-to-Controller Byte Channel

This block is a byte-wide, two-way message channel between a host I/O bus and a management controller. The host sees two I/O ports, one for data and one for status. The addresses of both ports are set by a single 32-bit register that the controller programs. The controller sees six registers:

- a control word;
- the packed port-address word;
- an interrupt-control byte;
- an inbound data byte;
- an outbound data byte;
- a status byte.

Two flags hold the handshake. Inbound-full is set when the host writes a byte and cleared when the controller reads it. Outbound-full is set when the controller writes a byte and cleared when the host reads it. The controller gets a level interrupt while an inbound byte is waiting, and it can mask that interrupt to hold the host off. The controller can also fire a one-cycle host interrupt pulse. A line number and a trigger type travel with the pulse for a downstream serializer to use.

Top module: `kcs_chan`

## Requirements
- R1: After reset, both flags are 0, the status byte is 0x00, the channel is disabled, `ctl_irq` and `host_irq` are low, and host reads return 0x00.
- R2: When enabled, a host write to the data port loads the inbound byte and sets inbound-full (status bit 1). A controller read of the inbound register (select 3) returns that byte and clears inbound-full.
- R3: A controller write to the outbound register (select 4) sets outbound-full (status bit 0). A host read of the data port returns the outbound byte.
- R4: A host read of the data port clears outbound-full only when auto-clear (interrupt-control bit 1) is 1. When auto-clear is 0, the flag stays set until the controller writes the status register.
- R5: `ctl_irq` is high exactly while inbound-full is 1 and interrupt enable (control bit 1) is 1.
- R6: While channel enable (control bit 0) is 0, host writes have no effect and host reads return 0x00.
- R7: The port-address register (select 1) gives the status-port address in bits 31:16 and the data-port address in bits 15:0. A changed address moves the decode, and the old address then gets no response.
- R8: A controller write to the status register (select 5) replaces all 8 bits, including both flags. The host status port returns the full byte.
- R9: The interrupt-control register (select 2) drives `host_irq_num` from bits 7:4 and `host_irq_type` from bits 3:2. Writing bit 0 as 1 gives a one-cycle `host_irq` pulse in the cycle after the write, and bit 0 then reads back as 0.
- R10: A host data write while inbound-full is already set replaces the inbound byte and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| host_irq | output | 1 | One-cycle host interrupt pulse |
| host_irq_num | output | 4 | Selected host interrupt line |
| host_irq_type | output | 2 | Trigger type: 00 low, 01 high, 11 rising, 10 reserved |
| ctl_addr | input | 3 | Controller register select |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_wdata | input | 32 | Controller write word |
| ctl_rdata | output | 32 | Controller read word (combinational) |
| ctl_irq | output | 1 | Controller interrupt, inbound byte waiting |

## Verification
A wrong flag shows up at the host status port on the very next host read. For inbound-full, it also shows on `ctl_irq` in the cycle after the access that updated the flag, because the interrupt is a combinational function of the registered flag and the enable. A stale data byte appears as soon as the matching side reads its data register. A bad address decode appears as a zero read or a lost write on the first access to the programmed port. A trigger bit that fails to self-clear shows as `host_irq` held high for a second cycle.

// File: rtl/kcs_chan.sv
module kcs_chan #(
  parameter logic [15:0] DATA_PORT_RST = 16'h0060,
  parameter logic [15:0] STAT_PORT_RST = 16'h0064
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_irq,
  output logic [3:0]  host_irq_num,
  output logic [1:0]  host_irq_type,
  input  logic [2:0]  ctl_addr,
  input  logic        ctl_wr,
  input  logic        ctl_rd,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  output logic        ctl_irq
);
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_PORT = 3'd1, SEL_IRQC = 3'd2,
                         SEL_IN   = 3'd3, SEL_OUT  = 3'd4, SEL_STAT = 3'd5;

  logic [1:0]  ctrl_q;
  logic [31:0] port_q;
  logic [7:0]  irqc_q, in_q, out_q, stat_q, stat_d;

  wire data_hit = ctrl_q[0] && (host_addr == port_q[15:0]);
  wire stat_hit = ctrl_q[0] && (host_addr == port_q[31:16]);
  wire hw_data  = host_wr && data_hit;
  wire hr_data  = host_rd && data_hit;
  wire cw_ctrl  = ctl_wr && ctl_addr == SEL_CTRL;
  wire cw_port  = ctl_wr && ctl_addr == SEL_PORT;
  wire cw_irqc  = ctl_wr && ctl_addr == SEL_IRQC;
  wire cw_out   = ctl_wr && ctl_addr == SEL_OUT;
  wire cw_stat  = ctl_wr && ctl_addr == SEL_STAT;
  wire cr_in    = ctl_rd && ctl_addr == SEL_IN;

  always_comb begin
    stat_d = stat_q;
    if (cw_stat) stat_d = ctl_wdata[7:0];
    if (cr_in) stat_d[1] = 1'b0;
    if (hr_data && irqc_q[1]) stat_d[0] = 1'b0;
    if (hw_data) stat_d[1] = 1'b1;
    if (cw_out) stat_d[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= {STAT_PORT_RST, DATA_PORT_RST};
      irqc_q <= '0;
      in_q   <= '0;
      out_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (cw_ctrl) ctrl_q <= ctl_wdata[1:0];
      if (cw_port) port_q <= ctl_wdata;
      if (cw_irqc) irqc_q <= ctl_wdata[7:0];
      else         irqc_q[0] <= 1'b0;
      if (hw_data) in_q <= host_wdata;
      if (cw_out)  out_q <= ctl_wdata[7:0];
    end
  end

  assign host_rdata    = data_hit ? out_q : (stat_hit ? stat_q : 8'h00);
  assign host_irq      = irqc_q[0];
  assign host_irq_num  = irqc_q[7:4];
  assign host_irq_type = irqc_q[3:2];
  assign ctl_irq       = stat_q[1] & ctrl_q[1];

  always_comb begin
    case (ctl_addr)
      SEL_CTRL: ctl_rdata = {30'd0, ctrl_q};
      SEL_PORT: ctl_rdata = port_q;
      SEL_IRQC: ctl_rdata = {24'd0, irqc_q};
      SEL_IN:   ctl_rdata = {24'd0, in_q};
      SEL_OUT:  ctl_rdata = {24'd0, out_q};
      SEL_STAT: ctl_rdata = {24'd0, stat_q};
      default:  ctl_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/kcs_chan_chk.sv
module kcs_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic ibf,
  input logic obf,
  input logic irq_en,
  input logic chan_en,
  input logic data_wr,
  input logic out_wr,
  input logic stat_wr,
  input logic ctl_irq,
  input logic host_irq
);
  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_irq |-> (ibf && irq_en));
  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ibf);
  // R3
  obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |=> obf);
  // R9
  host_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !stat_wr) |=> !$rose(ibf));
endmodule

bind kcs_chan kcs_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ibf(stat_q[1]), .obf(stat_q[0]),
  .irq_en(ctrl_q[1]), .chan_en(ctrl_q[0]), .data_wr(hw_data),
  .out_wr(cw_out), .stat_wr(cw_stat), .ctl_irq(ctl_irq), .host_irq(host_irq)
);

// File: tb/kcs_chan_tb_top.sv
module kcs_chan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, ctl_wr = 0, ctl_rd = 0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_irq, ctl_irq;
  logic [3:0] host_irq_num;
  logic [1:0] host_irq_type;
  logic [2:0] ctl_addr = '0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  int checks = 0, errors = 0, violations = 0;
  logic [15:0] dport = 16'h0060, sport = 16'h0064;
  logic model_ibf = 0;

  always #2 clk = ~clk;

  kcs_chan dut_i (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cw(logic [2:0] a, logic [31:0] d);
    @(negedge clk); ctl_addr = a; ctl_wdata = d; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic cr(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); ctl_addr = a; ctl_rd = 1; #1 d = ctl_rdata;
    @(negedge clk); ctl_rd = 0;
  endtask

  task automatic hw(logic [15:0] a, logic [7:0] d);
    if (a == dport && model_ibf) violations++;
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hr(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 ctl_irq", {31'd0, ctl_irq}, 0);
    check("R1 host_irq", {31'd0, host_irq}, 0);
    cr(3'd5, r); check("R1 status", r, 0);
    cr(3'd0, r); check("R1 control", r, 0);
    hr(sport, h); check("R1 host status read", {24'd0, h}, 0);

    hw(dport, 8'h5A);
    cr(3'd5, r); check("R6 write ignored while disabled", r, 0);
    cw(3'd4, 32'h77);
    hr(dport, h); check("R6 read zero while disabled", {24'd0, h}, 0);
    cw(3'd5, 0);

    cw(3'd0, 3);
    for (int v = 0; v < 256; v++) begin
      hw(dport, v[7:0]); model_ibf = 1;
      check("R5 irq on inbound", {31'd0, ctl_irq}, 1);
      cr(3'd3, r); model_ibf = 0;
      check("R2 inbound byte", r, v);
      cr(3'd5, r);
      check("R2 inbound-full cleared", {31'd0, r[1]}, 0);
      check("R5 irq dropped", {31'd0, ctl_irq}, 0);
    end

    cw(3'd0, 1);
    hw(dport, 8'h3C); model_ibf = 1;
    check("R5 masked", {31'd0, ctl_irq}, 0);
    hr(sport, h); check("R5 flag still set", {31'd0, h[1]}, 1);
    cw(3'd0, 3);
    check("R5 unmasked", {31'd0, ctl_irq}, 1);
    hw(dport, 8'hC3);
    hr(sport, h); check("R10 flag kept", {31'd0, h[1]}, 1);
    cr(3'd3, r); model_ibf = 0;
    check("R10 overwritten byte", r, 32'hC3);
    check("R10 protocol violation seen", violations, 1);

    cw(3'd2, 32'h02);
    for (int v = 0; v < 256; v += 17) begin
      cw(3'd4, v);
      hr(sport, h); check("R3 outbound-full set", {31'd0, h[0]}, 1);
      hr(dport, h); check("R3 outbound byte", {24'd0, h}, v);
      hr(sport, h); check("R4 auto-clear", {31'd0, h[0]}, 0);
    end
    cw(3'd2, 0);
    cw(3'd4, 32'h99);
    hr(dport, h);
    hr(sport, h); check("R4 no auto-clear keeps flag", {31'd0, h[0]}, 1);
    cw(3'd5, 0);
    hr(sport, h); check("R4 status write clears", {31'd0, h[0]}, 0);

    cw(3'd5, 32'hA6);
    hr(sport, h); check("R8 whole status byte", {24'd0, h}, 32'hA6);
    check("R8 written inbound flag drives irq", {31'd0, ctl_irq}, 1);
    cw(3'd5, 32'h01);
    hr(sport, h); check("R8 flags replaced", {24'd0, h}, 1);
    check("R8 irq off", {31'd0, ctl_irq}, 0);
    cw(3'd5, 0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] od;
      od = dport;
      dport = 16'h0200 + 16'(i * 2);
      sport = 16'h0300 + 16'(i * 3);
      cw(3'd1, {sport, dport});
      hw(od, 8'hEE);
      hr(sport, h); check("R7 old port ignored", {31'd0, h[1]}, 0);
      hw(dport, 8'(i + 1));
      hr(sport, h); check("R7 new status port", {31'd0, h[1]}, 1);
      cr(3'd3, r); check("R7 new data port", r, i + 1);
      hr(od, h); check("R7 old port reads zero", {24'd0, h}, 0);
    end

    for (int n = 0; n < 16; n++) begin
      for (int t = 0; t < 4; t++) begin
        cw(3'd2, 32'(n * 16 + t * 4 + 1));
        check("R9 pulse high", {31'd0, host_irq}, 1);
        check("R9 line number", {28'd0, host_irq_num}, n);
        check("R9 trigger type", {30'd0, host_irq_type}, t);
        @(negedge clk); #1;
        check("R9 pulse one cycle", {31'd0, host_irq}, 0);
        cr(3'd2, r); check("R9 trigger self-clears", {31'd0, r[0]}, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule